// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block turns a system I/O clock into a one-cycle bit-rate enable for an asynchronous serial channel. It does so through two cascaded down-counting dividers. The first stage is a prescaler with three sources: the I/O clock itself, or the underflow pulse of either of two free-running reload timers. The second stage is a programmable divider. It advances only on the prescaler's enable, and it raises the tick on its own underflow. The tick period is therefore the first-stage ratio times the second-stage ratio, in I/O clock cycles.

Software works out both ratios and writes each one minus one through a small write port. For example, a 15 MHz clock and a 38.4 kbit/s target need a timer reload of 3, a divider value of 97 and source code 01, which gives 392 clock cycles per bit. Every pulse is a clock enable, so all of the logic runs in the I/O clock domain.

Top module: `baud_gen`

## Requirements
- R1: A synchronous reset holds `tick` low, clears every counter and reload value to 0 and sets the source code to 00. With no writes after release, `tick` then asserts on every cycle.
- R2: The write port decodes `wr_addr` as follows. Address 0 takes the source code from `wr_data[1:0]`. Address 1 is the reload value of timer A and address 2 is the reload value of timer B. Address 3 takes the divider reload from `wr_data[DIV_W-1:0]`.
- R3: With source code 00 and divider reload D, `tick` pulses every D+1 cycles.
- R4: With source code 01, timer A reload A and divider reload D, `tick` pulses every (A+1)*(D+1) cycles.
- R5: With source code 11, timer B reload B and divider reload D, `tick` pulses every (B+1)*(D+1) cycles.
- R6: Source code 10 is reserved. While it is selected the second stage does not count and `tick` stays low.
- R7: A new divider reload written during a count does not change the interval in progress. It takes effect from the next underflow.
- R8: A new timer reload written during a count does not change the timer period in progress. It takes effect from the next underflow of that timer.
- R9: When the overall ratio exceeds 1, each `tick` pulse is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | TMR_W | Write data |
| tick | output | 1 | One-cycle bit-rate enable |

## Verification
The assertions assume that reset is held for at least one edge before any check matters, and that `wr_addr` and `wr_data` carry known values whenever `wr_en` is high. The underflow and hold properties also assume that the source code changes only through the write port. The stimulus applies reset at the start of every configuration and writes only during steady cycles. Before it measures an interval, it lets two ticks pass, so the counters have reloaded under the new values.

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int TMR_W = 8,
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic             tick
);

  localparam logic [1:0] SRC_CLK = 2'b00;
  localparam logic [1:0] SRC_TA  = 2'b01;
  localparam logic [1:0] SRC_TB  = 2'b11;

  logic [1:0]       sel;
  logic [TMR_W-1:0] rel_a, rel_b, cnt_a, cnt_b;
  logic [DIV_W-1:0] rel_d, dcnt;
  logic             uf_a, uf_b, pre_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= SRC_CLK;
      rel_a <= '0;
      rel_b <= '0;
      rel_d <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: sel   <= wr_data[1:0];
        2'd1: rel_a <= wr_data;
        2'd2: rel_b <= wr_data;
        default: rel_d <= wr_data[DIV_W-1:0];
      endcase
    end
  end

  assign uf_a = (cnt_a == '0);
  assign uf_b = (cnt_b == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else begin
      cnt_a <= uf_a ? rel_a : cnt_a - 1'b1;
      cnt_b <= uf_b ? rel_b : cnt_b - 1'b1;
    end
  end

  always_comb begin
    case (sel)
      SRC_CLK: pre_en = 1'b1;
      SRC_TA:  pre_en = uf_a;
      SRC_TB:  pre_en = uf_b;
      default: pre_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= pre_en && (dcnt == '0);
      if (pre_en) dcnt <= (dcnt == '0) ? rel_d : dcnt - 1'b1;
    end
  end

endmodule

module baud_gen_chk #(
  parameter int TMR_W = 8,
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       sel,
  input logic             pre_en,
  input logic             uf_a,
  input logic [TMR_W-1:0] cnt_a,
  input logic [TMR_W-1:0] rel_a,
  input logic [DIV_W-1:0] dcnt,
  input logic             tick
);

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !tick);

  a_r6_reserved_silent: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b10 && $past(sel) == 2'b10) |-> !tick);

  a_r6_divider_holds: assert property (@(posedge clk) disable iff (rst)
    !pre_en |=> $stable(dcnt));

  a_r3_tick_follows_prescale: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(pre_en));

  a_r8_timer_reload: assert property (@(posedge clk) disable iff (rst)
    uf_a |=> cnt_a == $past(rel_a));

endmodule

bind baud_gen baud_gen_chk #(.TMR_W(TMR_W), .DIV_W(DIV_W)) i_chk (
  .clk(clk), .rst(rst), .sel(sel), .pre_en(pre_en), .uf_a(uf_a),
  .cnt_a(cnt_a), .rel_a(rel_a), .dcnt(dcnt), .tick(tick)
);

// File: tb/test_baud_gen.sv
`timescale 1ns/100ps
module test_baud_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  baud_gen i_baud_gen (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                       .wr_data(wr_data), .tick(tick));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic sync_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic interval(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick);
  endtask

  task automatic run_cfg(input logic [1:0] s, input int a, input int b, input int d,
                         input int exp, input string req);
    int n;
    do_reset();
    wr(2'd1, 8'(a)); wr(2'd2, 8'(b)); wr(2'd3, 8'(d)); wr(2'd0, {6'b0, s});
    sync_tick(); sync_tick();
    for (int k = 0; k < 2; k++) begin
      interval(n);
      check(req, n, exp);
    end
    if (exp > 1) begin
      @(negedge clk);
      check("R9 width", int'(tick), 0);
    end
  endtask

  initial begin
    #(5ns * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, cnt;
    repeat (3) @(negedge clk);
    check("R1 tick low in reset", int'(tick), 0);
    rst = 1'b0;
    sync_tick();
    interval(n);
    check("R1 default ratio one", n, 1);

    for (int a = 0; a < 4; a++)
      for (int d = 0; d < 5; d++) begin
        run_cfg(2'b00, a, a + 2, d, d + 1, "R3 clk source");
        run_cfg(2'b01, a, a + 2, d, (a + 1) * (d + 1), "R4 timer A");
        run_cfg(2'b11, a, a + 2, d, (a + 3) * (d + 1), "R5 timer B");
      end

    run_cfg(2'b01, 3, 0, 97, 392, "R4 38.4k at 15MHz");
    run_cfg(2'b00, 0, 0, 64, 65, "R3 230.4k at 15MHz");
    run_cfg(2'b11, 0, 255, 127, 256 * 128, "R2 full width B");

    do_reset();
    wr(2'd3, 8'd3);
    wr(2'd0, 8'b1111_1110);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (tick) cnt++; end
    check("R6 reserved no tick", cnt, 0);
    wr(2'd0, 8'h00);
    sync_tick(); sync_tick();
    interval(n);
    check("R2 sel upper bits ignored", n, 4);

    do_reset();
    wr(2'd3, 8'd9);
    sync_tick(); sync_tick();
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'd2;
    @(negedge clk); wr_en = 1'b0; n = 1;
    while (!tick) begin @(negedge clk); n++; end
    check("R7 divider old interval", n, 10);
    interval(n);
    check("R7 divider new interval", n, 3);

    do_reset();
    wr(2'd1, 8'd4); wr(2'd0, 8'd1);
    sync_tick(); sync_tick();
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd1;
    @(negedge clk); wr_en = 1'b0; n = 1;
    while (!tick) begin @(negedge clk); n++; end
    check("R8 timer old period", n, 5);
    interval(n);
    check("R8 timer new period", n, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule